// File: doc/BRIEF.md
# Debounced Keypad Matrix Scanner

This block scans a key matrix of up to eight lines by eight lines. One side of the matrix is driven one line at a time while the other side is sampled. Either the rows or the columns can be the driven side. At each tick of a slow scan enable, the block samples the sense lines for the current drive line and moves on to the next one. Once every active drive line has been visited, the block has a complete 64-position picture of the keys.

That picture passes through two stability filters in series, each of which can be bypassed. The first works on the raw sampled frame and the second on the status that results from it. The filtered result is presented as two 32-bit status words: rows 0 to 3 in the low word and rows 4 to 7 in the high word. Software or a neighbouring block reads these words. A control word sets the block's behaviour: the enable, the pull mode, the active row and column counts, and the two filter periods. A drive word holds the two pin-drive masks.

Top module: `kp_matrix_scanner`

## Requirements
- R1: After reset, both status words are zero and no row or column pin has its output enable set.
- R2: While enabled (control bit 0 set), the rows are driven if the row mask (drive word bits 31:24) is non-zero, and the columns are driven otherwise (mask in bits 23:16). The output enables equal that mask. Only the current drive line sits at the active level and every other line sits at the idle level. The first line after enabling is line 0, and each scan tick advances the drive by one line.
- R3: The key at row r and column c appears in bit (r mod 4)*8+c of the low word when r<4, and of the high word when r>=4.
- R4: With control bit 1 set (pull-up), a status bit of 0 means pressed and the active drive level is 0. With bit 1 clear, a status bit of 1 means pressed and the active drive level is 1.
- R5: The active row count minus one is held in control bits 22:20, and the active column count minus one in bits 18:16. Positions outside these counts read as not pressed.
- R6: Driving the columns and sensing the rows produces the same status mapping as driving the rows.
- R7: When the column filter is enabled (bit 11) with period code k (bits 10:8), a change becomes visible only after it has been present in 2^(k+1) consecutive scan frames, and not one frame earlier.
- R8: The status filter (enable bit 15, code in bits 14:12) follows the same rule. When both filters are enabled, a change needs need_col+need_stat-1 frames to appear.
- R9: A change that lasts fewer frames than the filter period never appears in the status.
- R10: Clearing the whole control word stops the scan and drops every output enable. The status words then hold their last values, including the pull-mode inversion that was in force.
- R11: With both filters disabled, a key that is applied before a frame starts appears in the status at the end of that single frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_tick | input | 1 | Scan clock enable: one drive step per pulse |
| ctrl_word | input | 32 | Enable, pull mode, filter settings, counts |
| drive_word | input | 32 | Row output mask [31:24], column output mask [23:16] |
| row_in | input | 8 | Sampled row lines |
| col_in | input | 8 | Sampled column lines |
| row_out | output | 8 | Row drive levels |
| row_oe | output | 8 | Row output enables |
| col_out | output | 8 | Column drive levels |
| col_oe | output | 8 | Column output enables |
| stat_lo | output | 32 | Key status, rows 0 to 3 |
| stat_hi | output | 32 | Key status, rows 4 to 7 |

## Verification
A wrong scan index shows up within one tick as a drive pattern that is missing its single active line or has it in the wrong place. Within one frame it also shows up as a key landing on the wrong status bit. A miscounting filter shows up as a status change exactly one frame early or one frame late, so the filter checks sample on both sides of the expected frame. A sweep that presses every single position under both pull modes exposes any mapping or polarity slip at the first frame after the key is applied.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int KP_LINES   = 8;
  localparam int KP_CODE_W  = 3;
  localparam int KP_WORD_W  = 32;

  localparam int BIT_EN     = 0;
  localparam int BIT_PULL   = 1;
  localparam int LSB_CCODE  = 8;
  localparam int BIT_CEN    = 11;
  localparam int LSB_SCODE  = 12;
  localparam int BIT_SEN    = 15;
  localparam int LSB_COLS   = 16;
  localparam int LSB_ROWS   = 20;
  localparam int LSB_CMASK  = 16;
  localparam int LSB_RMASK  = 24;

  typedef struct packed {
    logic [2:0] rows_m1;
    logic [2:0] cols_m1;
    logic       stat_en;
    logic [2:0] stat_code;
    logic       col_en;
    logic [2:0] col_code;
    logic       pull_up;
    logic       enable;
  } kp_cfg_t;

  function automatic kp_cfg_t kp_decode(input logic [KP_WORD_W-1:0] w);
    kp_cfg_t c;
    c.rows_m1   = w[LSB_ROWS +: 3];
    c.cols_m1   = w[LSB_COLS +: 3];
    c.stat_en   = w[BIT_SEN];
    c.stat_code = w[LSB_SCODE +: 3];
    c.col_en    = w[BIT_CEN];
    c.col_code  = w[LSB_CCODE +: 3];
    c.pull_up   = w[BIT_PULL];
    c.enable    = w[BIT_EN];
    return c;
  endfunction
endpackage

// File: rtl/kp_stable_filter.sv
module kp_stable_filter #(
  parameter int W      = 64,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [W-1:0]      in_i,
  output logic [W-1:0]      out_o
);
  localparam int CNT_W = (1 << CODE_W) + 2;

  logic [W-1:0]     cand_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] cnt_inc;
  logic             same;

  always_comb begin
    need    = CNT_W'(1) << (CNT_W'(code_i) + CNT_W'(1));
    same    = (in_i == cand_q);
    cnt_inc = (cnt_q == {CNT_W{1'b1}}) ? cnt_q : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= '0;
      cnt_q  <= '0;
      out_o  <= '0;
    end else if (upd_i) begin
      cand_q <= in_i;
      cnt_q  <= same ? cnt_inc : CNT_W'(1);
      if (!en_i)
        out_o <= in_i;
      else if (same && cnt_inc >= need)
        out_o <= in_i;
    end
  end

  // R7
  filt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> $stable(out_o));
  // R9
  filt_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_i && en_i && (in_i != cand_q)) |=> $stable(out_o));
  // R11
  filt_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !en_i) |=> (out_o == $past(in_i)));
endmodule

// File: rtl/kp_line_scan.sv
module kp_line_scan #(
  parameter int LINES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en_i,
  input  logic                     pull_i,
  input  logic                     tick_i,
  input  logic                     row_side_i,
  input  logic [2:0]               rows_m1_i,
  input  logic [2:0]               cols_m1_i,
  input  logic [LINES-1:0]         row_mask_i,
  input  logic [LINES-1:0]         col_mask_i,
  input  logic [LINES-1:0]         row_in,
  input  logic [LINES-1:0]         col_in,
  output logic [LINES-1:0]         row_out,
  output logic [LINES-1:0]         row_oe,
  output logic [LINES-1:0]         col_out,
  output logic [LINES-1:0]         col_oe,
  output logic [LINES*LINES-1:0]   frame_o,
  output logic                     frame_stb_o
);
  localparam int KEYS  = LINES * LINES;
  localparam int IDX_W = $clog2(LINES);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;
  logic [KEYS-1:0]  shadow_q;
  logic [KEYS-1:0]  shadow_n;
  logic [LINES-1:0] pressed;
  logic [LINES-1:0] line_vec;

  always_comb begin
    last_idx = row_side_i ? IDX_W'(rows_m1_i) : IDX_W'(cols_m1_i);
    pressed  = (row_side_i ? col_in : row_in) ^ {LINES{pull_i}};
    shadow_n = (idx_q == '0) ? '0 : shadow_q;
    for (int j = 0; j < LINES; j++) begin
      if (row_side_i)
        shadow_n[int'(idx_q)*LINES + j] = pressed[j] && (j <= int'(cols_m1_i));
      else
        shadow_n[j*LINES + int'(idx_q)] = pressed[j] && (j <= int'(rows_m1_i));
    end
    line_vec = {LINES{pull_i}};
    line_vec[idx_q] = ~pull_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q       <= '0;
      shadow_q    <= '0;
      frame_o     <= '0;
      frame_stb_o <= 1'b0;
      row_out     <= '0;
      row_oe      <= '0;
      col_out     <= '0;
      col_oe      <= '0;
    end else begin
      frame_stb_o <= 1'b0;
      if (!en_i) begin
        idx_q <= '0;
      end else if (tick_i) begin
        shadow_q <= shadow_n;
        if (idx_q >= last_idx) begin
          idx_q       <= '0;
          frame_o     <= shadow_n;
          frame_stb_o <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
      row_out <= row_side_i ? line_vec : {LINES{pull_i}};
      col_out <= row_side_i ? {LINES{pull_i}} : line_vec;
      row_oe  <= (en_i && row_side_i)  ? row_mask_i : '0;
      col_oe  <= (en_i && !row_side_i) ? col_mask_i : '0;
    end
  end

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    en_i |-> (idx_q <= last_idx));
  // R2
  one_active_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0((row_out ^ {LINES{pull_i}}) & row_oe) && $onehot0((col_out ^ {LINES{pull_i}}) & col_oe));
  // R2
  single_side_chk: assert property (@(posedge clk) disable iff (rst)
    !((|row_oe) && (|col_oe)));
endmodule

// File: rtl/kp_matrix_scanner.sv
module kp_matrix_scanner
  import kp_pkg::*;
#(
  parameter int LINES  = KP_LINES,
  parameter int CODE_W = KP_CODE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scan_tick,
  input  logic [KP_WORD_W-1:0] ctrl_word,
  input  logic [KP_WORD_W-1:0] drive_word,
  input  logic [LINES-1:0]     row_in,
  input  logic [LINES-1:0]     col_in,
  output logic [LINES-1:0]     row_out,
  output logic [LINES-1:0]     row_oe,
  output logic [LINES-1:0]     col_out,
  output logic [LINES-1:0]     col_oe,
  output logic [KP_WORD_W-1:0] stat_lo,
  output logic [KP_WORD_W-1:0] stat_hi
);
  localparam int KEYS = LINES * LINES;

  kp_cfg_t          cfg;
  logic             pull_q;
  logic             pull_eff;
  logic [LINES-1:0] row_mask;
  logic [LINES-1:0] col_mask;
  logic             row_side;
  logic [KEYS-1:0]  frame;
  logic             frame_stb;
  logic             stb_d;
  logic [KEYS-1:0]  col_filt;
  logic [KEYS-1:0]  stat_filt;
  logic [KEYS-1:0]  stat_q;

  always_comb begin
    cfg      = kp_decode(ctrl_word);
    pull_eff = cfg.enable ? cfg.pull_up : pull_q;
    row_mask = drive_word[LSB_RMASK +: LINES];
    col_mask = drive_word[LSB_CMASK +: LINES];
    row_side = |row_mask;
  end

  kp_line_scan #(.LINES(LINES)) u_scan (
    .clk(clk), .rst(rst), .en_i(cfg.enable), .pull_i(pull_eff), .tick_i(scan_tick),
    .row_side_i(row_side), .rows_m1_i(cfg.rows_m1), .cols_m1_i(cfg.cols_m1),
    .row_mask_i(row_mask), .col_mask_i(col_mask), .row_in(row_in), .col_in(col_in),
    .row_out(row_out), .row_oe(row_oe), .col_out(col_out), .col_oe(col_oe),
    .frame_o(frame), .frame_stb_o(frame_stb)
  );

  kp_stable_filter #(.W(KEYS), .CODE_W(CODE_W)) u_col_filt (
    .clk(clk), .rst(rst), .upd_i(frame_stb), .en_i(cfg.col_en),
    .code_i(cfg.col_code[CODE_W-1:0]), .in_i(frame), .out_o(col_filt)
  );

  kp_stable_filter #(.W(KEYS), .CODE_W(CODE_W)) u_stat_filt (
    .clk(clk), .rst(rst), .upd_i(stb_d), .en_i(cfg.stat_en),
    .code_i(cfg.stat_code[CODE_W-1:0]), .in_i(col_filt), .out_o(stat_filt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_q <= 1'b0;
      stb_d  <= 1'b0;
      stat_q <= '0;
    end else begin
      if (cfg.enable) pull_q <= cfg.pull_up;
      stb_d  <= frame_stb;
      stat_q <= stat_filt ^ {KEYS{pull_eff}};
    end
  end

  assign stat_lo = stat_q[KP_WORD_W-1:0];
  assign stat_hi = stat_q[2*KP_WORD_W-1:KP_WORD_W];

  // R10
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg.enable && $past(!cfg.enable) && $past(!cfg.enable, 2) && $past(!cfg.enable, 3))
      |-> ($stable(stat_lo) && $stable(stat_hi)));
  // R10
  no_drive_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg.enable && $past(!cfg.enable)) |-> (row_oe == '0 && col_oe == '0));
endmodule

// File: tb/tb_kp_matrix_scanner.sv
module tb_kp_matrix_scanner;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scan_tick = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic [31:0] drive_word = '0;
  logic [7:0]  row_in, col_in, row_out, row_oe, col_out, col_oe;
  logic [31:0] stat_lo, stat_hi;

  logic [63:0] keys = '0;
  logic        pull_m = 1'b0;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  kp_matrix_scanner dut (
    .clk(clk), .rst(rst), .scan_tick(scan_tick), .ctrl_word(ctrl_word),
    .drive_word(drive_word), .row_in(row_in), .col_in(col_in),
    .row_out(row_out), .row_oe(row_oe), .col_out(col_out), .col_oe(col_oe),
    .stat_lo(stat_lo), .stat_hi(stat_hi)
  );

  // key matrix model: a pressed key ties its row line to its column line
  always_comb begin
    col_in = {8{pull_m}};
    row_in = {8{pull_m}};
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        if (keys[r*8+c]) begin
          if (row_oe[r] && row_out[r] == ~pull_m) col_in[c] = ~pull_m;
          if (col_oe[c] && col_out[c] == ~pull_m) row_in[r] = ~pull_m;
        end
  end

  function automatic logic [31:0] mk_ctrl(input logic en, input logic pu, input int rm1,
      input int cm1, input logic cen, input int cc, input logic sen, input int sc);
    return 32'(en) | (32'(pu) << 1) | (32'(cc) << 8) | (32'(cen) << 11) |
           (32'(sc) << 12) | (32'(sen) << 15) | (32'(cm1) << 16) | (32'(rm1) << 20);
  endfunction

  function automatic logic [63:0] exp_stat(input logic [63:0] k, input int nr, input int nc,
      input logic pu);
    logic [63:0] v = '0;
    for (int r = 0; r < nr; r++)
      for (int c = 0; c < nc; c++)
        v[(r/4)*32 + (r%4)*8 + c] = k[r*8+c];
    return v ^ {64{pu}};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick1();
    @(negedge clk) scan_tick = 1'b1;
    @(negedge clk) scan_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic frames(input int n, input int lines);
    repeat (n*lines) tick1();
    repeat (6) @(negedge clk);
  endtask

  task automatic configure(input logic [31:0] cw, input logic [31:0] dw);
    @(negedge clk) ctrl_word = '0;
    repeat (2) @(negedge clk);
    pull_m = cw[1];
    drive_word = dw;
    ctrl_word = cw;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [63:0] st();
    return {stat_hi, stat_lo};
  endfunction

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 status", st(), 64'h0);
    chk("R1 oe", {48'h0, row_oe, col_oe}, 64'h0);

    // R2: row drive, pull-down, then pull-up
    configure(mk_ctrl(1, 0, 7, 7, 0, 0, 0, 0), 32'hFF00_0000);
    chk("R2 row_oe", 64'(row_oe), 64'hFF);
    chk("R2 col_oe", 64'(col_oe), 64'h0);
    chk("R2 line0", 64'(row_out), 64'h01);
    tick1();
    chk("R2 line1", 64'(row_out), 64'h02);
    configure(mk_ctrl(1, 1, 7, 7, 0, 0, 0, 0), 32'hFF00_0000);
    chk("R4 pullup line0", 64'(row_out), 64'hFE);
    configure(mk_ctrl(1, 0, 7, 7, 0, 0, 0, 0), 32'h00FF_0000);
    chk("R2 col side oe", {48'h0, row_oe, col_oe}, 64'h00FF);
    chk("R2 col side line0", 64'(col_out), 64'h01);

    // R3 R4 R11: every single position, both pull modes, one frame latency
    for (int p = 0; p < 2; p++) begin
      configure(mk_ctrl(1, p[0], 7, 7, 0, 0, 0, 0), 32'hFF00_0000);
      for (int k = 0; k < 64; k++) begin
        keys = 64'h1 << k;
        frames(1, 8);
        chk(p ? "R3 R4 R11 pull-up key" : "R3 R11 pull-down key", st(), exp_stat(keys, 8, 8, p[0]));
      end
      keys = 64'hA55A_3CC3_0FF0_9669;
      frames(1, 8);
      chk("R3 multi-key", st(), exp_stat(keys, 8, 8, p[0]));
    end

    // R5: 3 rows x 5 columns, rows driven
    configure(mk_ctrl(1, 0, 2, 4, 0, 0, 0, 0), 32'h0700_0000);
    keys = '1;
    frames(2, 3);
    chk("R5 out-of-range idle", st(), exp_stat(keys, 3, 5, 0));
    // R6: same counts, columns driven
    configure(mk_ctrl(1, 0, 2, 4, 0, 0, 0, 0), 32'h001F_0000);
    keys = 64'h0000_0000_0015_0A13 | 64'h8000_0000_0000_0000;
    frames(2, 5);
    chk("R6 column drive", st(), exp_stat(keys, 3, 5, 0));
    configure(mk_ctrl(1, 1, 7, 7, 0, 0, 0, 0), 32'h00FF_0000);
    keys = 64'h0123_4567_89AB_CDEF;
    frames(1, 8);
    chk("R6 column drive pull-up", st(), exp_stat(keys, 8, 8, 1));

    // R7: column filter periods 2, 4, 8 frames
    for (int code = 0; code < 3; code++) begin
      configure(mk_ctrl(1, 0, 7, 7, 1, code, 0, 0), 32'hFF00_0000);
      keys = '0;
      frames(12, 8);
      keys = 64'h1 << (9 + code);
      frames((2 << code) - 1, 8);
      chk("R7 col filter early", st(), 64'h0);
      frames(1, 8);
      chk("R7 col filter on time", st(), exp_stat(keys, 8, 8, 0));
    end

    // R8: status filter alone, then both in series
    configure(mk_ctrl(1, 0, 7, 7, 0, 0, 1, 1), 32'hFF00_0000);
    keys = '0;
    frames(12, 8);
    keys = 64'h0000_0100_0000_0000;
    frames(3, 8);
    chk("R8 stat filter early", st(), 64'h0);
    frames(1, 8);
    chk("R8 stat filter on time", st(), exp_stat(keys, 8, 8, 0));
    configure(mk_ctrl(1, 0, 7, 7, 1, 0, 1, 0), 32'hFF00_0000);
    keys = '0;
    frames(12, 8);
    keys = 64'h0000_0000_0400_0000;
    frames(2, 8);
    chk("R8 series early", st(), 64'h0);
    frames(1, 8);
    chk("R8 series on time", st(), exp_stat(keys, 8, 8, 0));

    // R9: bounce of 3 frames against a 4-frame period
    configure(mk_ctrl(1, 0, 7, 7, 1, 1, 0, 0), 32'hFF00_0000);
    keys = '0;
    frames(12, 8);
    keys = 64'h0000_0000_0000_0080;
    frames(3, 8);
    chk("R9 bounce hidden", st(), 64'h0);
    keys = '0;
    frames(6, 8);
    chk("R9 bounce never shown", st(), 64'h0);

    // R10: pull-up status held after the whole control word is cleared
    configure(mk_ctrl(1, 1, 7, 7, 0, 0, 0, 0), 32'hFF00_0000);
    keys = 64'h0000_0020_0000_0000;
    frames(1, 8);
    held = st();
    chk("R10 before stop", held, exp_stat(keys, 8, 8, 1));
    @(negedge clk) ctrl_word = '0;
    repeat (3) @(negedge clk);
    chk("R10 no drive", {48'h0, row_oe, col_oe}, 64'h0);
    keys = 64'hFFFF_0000_FFFF_0000;
    frames(3, 8);
    chk("R10 status held", st(), held);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule